// File: doc/BRIEF.md
# Serial Output Bit Advancement Timer

This block produces the timing that the serial output shift registers of a TDM switch use to launch their bits. It counts system clocks from the frame pulse and reports, for every cycle, which channel and which bit of that channel is being sent. It also gives a one-cycle strobe on the first clock of each bit and a one-cycle marker on the first clock of a frame. The whole timing can be moved earlier than the frame pulse by a programmable number of system clocks. This lets launched data meet the far end's sampling point despite output and board delays.

The stream rate is chosen by `rate_sel`: a bit lasts 8 system clocks at the low rate and 4 at the high rate. The 2-bit `adv_code` selects how far the timing is advanced. At the low rate each code step is 2 clocks (0, 2, 4 or 6). At the high rate each step is 1 clock (0, 1, 2 or 3). A frame holds `CHANNELS` channels, and each channel sends bit 7 first and bit 0 last. Rate and code are taken only together with a frame pulse, so a frame is never timed with a mix of settings. Between frame pulses the counters run freely and wrap from the last channel's bit 0 to channel 0 bit 7.

Top module: `tdm_bit_advance`

## Requirements
- R1: `frame_start` is high for exactly the cycles in which the advanced position is channel 0, bit 7, first clock of the bit; `bit_strobe` is high in those cycles too.
- R2: With `rate_sel`=0 a bit lasts 8 clocks, and with `rate_sel`=1 it lasts 4 clocks. `bit_strobe` is high on the first clock of each bit and low on the others.
- R3: Within a channel `bit_idx` steps 7, 6, …, 0, and `chan` counts upward from 0 to `CHANNELS`-1, advancing after bit 0.
- R4: `chan` and `bit_idx` change only in cycles where `bit_strobe` is high, apart from the first cycle after a frame pulse.
- R5: Without a new frame pulse, channel `CHANNELS`-1 bit 0 is followed directly by channel 0 bit 7 with `frame_start`. The frame length is `CHANNELS`×64 clocks at `rate_sel`=0 and `CHANNELS`×32 clocks at `rate_sel`=1.
- R6: At `rate_sel`=0, code c advances the timing by 2·c clocks. The first cycle after the clock edge that samples `frame_pulse` high is at advanced position 2·c, counted in clocks from channel 0 bit 7.
- R7: At `rate_sel`=1, code c advances the timing by c clocks. The first cycle after the sampling edge is at advanced position c.
- R8: `rate_sel` and `adv_code` are sampled only at an edge where `frame_pulse` is high. Changes at any other time have no effect on the outputs.
- R9: During reset and until the first frame pulse, the block uses the low rate with code 1 (2 clocks of advance). In reset the position is held at 2, so the outputs show channel 0, bit 7, with no strobe. After reset is released the position counts up by one each clock.
- R10: A frame pulse arriving at any point in a frame realigns the counters at once, as described in R6 and R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_pulse | input | 1 | Frame reference; the cycle after it is nominal frame position 0 |
| rate_sel | input | 1 | 0: 8-clock bits, 1: 4-clock bits |
| adv_code | input | 2 | Advancement step count, 0 to 3 |
| bit_strobe | output | 1 | High on the first clock of each bit |
| frame_start | output | 1 | High on the first clock of channel 0 bit 7 |
| chan | output | $clog2(CHANNELS) | Channel being launched |
| bit_idx | output | 3 | Bit being launched, 7 first |

## Verification
A wrong position register or a wrong advance offset moves every output at once. The error shows at the ports in the first cycle after the frame pulse, as a shifted strobe phase or a wrong starting bit. A faulty wrap or a faulty frame-length mask only shows at the end of the frame, so each configuration is run past two full frames. A setting that is latched at the wrong time shows as a changed strobe phase right after a mid-frame input change. The bench therefore keeps checking across that change.

// File: rtl/tdm_bit_advance.sv
module tdm_bit_advance #(
  parameter int CHANNELS = 256,
  localparam int CH_W = $clog2(CHANNELS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_pulse,
  input  logic            rate_sel,
  input  logic [1:0]      adv_code,
  output logic            bit_strobe,
  output logic            frame_start,
  output logic [CH_W-1:0] chan,
  output logic [2:0]      bit_idx
);
  localparam int POS_W = CH_W + 6;

  logic [POS_W-1:0] ref_pos;
  logic             rate_q;
  logic [1:0]       code_q;

  wire [POS_W-1:0] wrap_mask = rate_q ? {1'b0, {(POS_W-1){1'b1}}} : {POS_W{1'b1}};
  wire [POS_W-1:0] adv_clks  = rate_q ? POS_W'(code_q) : POS_W'({code_q, 1'b0});
  wire [POS_W-1:0] adv_pos   = (ref_pos + adv_clks) & wrap_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_pos <= '0;
      rate_q  <= 1'b0;
      code_q  <= 2'b01;
    end else if (frame_pulse) begin
      ref_pos <= '0;
      rate_q  <= rate_sel;
      code_q  <= adv_code;
    end else begin
      ref_pos <= (ref_pos + POS_W'(1)) & wrap_mask;
    end
  end

  assign bit_strobe  = rate_q ? (adv_pos[1:0] == 2'd0) : (adv_pos[2:0] == 3'd0);
  assign bit_idx     = 3'd7 - (rate_q ? adv_pos[4:2] : adv_pos[5:3]);
  assign chan        = rate_q ? adv_pos[POS_W-2:5] : adv_pos[POS_W-1:6];
  assign frame_start = (adv_pos == '0);

  logic [3:0] gap;
  logic       seen_strobe, pulse_since;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap         <= '0;
      seen_strobe <= 1'b0;
      pulse_since <= 1'b0;
    end else if (bit_strobe) begin
      gap         <= 4'd1;
      seen_strobe <= 1'b1;
      pulse_since <= frame_pulse;
    end else begin
      gap         <= (gap == 4'd15) ? gap : gap + 4'd1;
      pulse_since <= pulse_since | frame_pulse;
    end
  end

  a_r2_bit_period: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_strobe && seen_strobe && !pulse_since) |-> (gap == (rate_q ? 4'd4 : 4'd8)));

  a_r1_frame_start_pos: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (bit_strobe && chan == '0 && bit_idx == 3'd7));

  a_r4_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_strobe && !$past(frame_pulse)) |-> ($stable(chan) && $stable(bit_idx)));

  a_r5_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !$past(frame_pulse)) |->
      ($past(chan) == CH_W'(CHANNELS-1) && $past(bit_idx) == 3'd0));
endmodule

// File: tb/sim_tdm_bit_advance.sv
`timescale 1ns/1ps
module sim_tdm_bit_advance;
  localparam int CH = 8;
  localparam int CW = $clog2(CH);

  logic clk = 0, rst_n = 0, frame_pulse = 0, rate_sel = 0;
  logic [1:0] adv_code = 0;
  logic bit_strobe, frame_start;
  logic [CW-1:0] chan;
  logic [2:0] bit_idx;
  int vecs = 0, errs = 0;
  logic [CW-1:0] prev_chan;
  logic [2:0] prev_bit;

  always #4 clk = ~clk;

  tdm_bit_advance #(.CHANNELS(CH)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .rate_sel(rate_sel),
    .adv_code(adv_code), .bit_strobe(bit_strobe), .frame_start(frame_start),
    .chan(chan), .bit_idx(bit_idx));

  task automatic check(input int n, input bit rate, input int code, input string tag, input bit hold_ok);
    int fr, len, a, e_bit, e_chan;
    bit e_str, e_fs;
    fr    = rate ? CH*32 : CH*64;
    len   = rate ? 4 : 8;
    a     = (n + (rate ? code : 2*code)) % fr;
    e_str = (a % len) == 0;
    e_bit = 7 - ((a / len) % 8);
    e_chan = a / (len*8);
    e_fs  = (a == 0);
    vecs++;
    if (bit_strobe !== e_str) begin errs++;
      $display("FAIL %s/R2 strobe n=%0d got %0b exp %0b", tag, n, bit_strobe, e_str); end
    if (bit_idx !== 3'(e_bit)) begin errs++;
      $display("FAIL %s/R3 bit_idx n=%0d got %0d exp %0d", tag, n, bit_idx, e_bit); end
    if (chan !== CW'(e_chan)) begin errs++;
      $display("FAIL %s/R5 chan n=%0d got %0d exp %0d", tag, n, chan, e_chan); end
    if (frame_start !== e_fs) begin errs++;
      $display("FAIL %s/R1 frame_start n=%0d got %0b exp %0b", tag, n, frame_start, e_fs); end
    if (hold_ok && !e_str && (chan !== prev_chan || bit_idx !== prev_bit)) begin errs++;
      $display("FAIL R4 hold n=%0d got %0d/%0d exp %0d/%0d", n, chan, bit_idx, prev_chan, prev_bit); end
    prev_chan = chan;
    prev_bit  = bit_idx;
  endtask

  task automatic pulse(input bit rate, input int code);
    @(negedge clk);
    frame_pulse = 1; rate_sel = rate; adv_code = 2'(code);
    @(negedge clk);
    frame_pulse = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired, R1 to R10 unfinished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    // R9: reset state and default advance
    repeat (3) begin @(negedge clk); check(0, 0, 1, "R9", 0); end
    rst_n = 1;
    check(0, 0, 1, "R9", 0);
    for (int n = 1; n < 200; n++) begin @(negedge clk); check(n, 0, 1, "R9", 1); end

    // R6, R7 sweep; R8 mid-frame input change
    for (int r = 0; r < 2; r++) begin
      for (int c = 0; c < 4; c++) begin
        int fr;
        fr = r ? CH*32 : CH*64;
        pulse(r[0], c);
        check(0, r[0], c, r ? "R7" : "R6", 0);
        for (int n = 1; n < 2*fr + 20; n++) begin
          @(negedge clk);
          if (n == fr/2 + 3) begin rate_sel = ~r[0]; adv_code = 2'(3 - c); end
          check(n, r[0], c, (n > fr/2 + 3) ? "R8" : (r ? "R7" : "R6"), 1);
        end
      end
    end

    // R10: realign from a mid-frame pulse
    pulse(0, 3);
    for (int n = 0; n < 37; n++) begin if (n > 0) @(negedge clk); check(n, 0, 3, "R10", n > 0); end
    pulse(1, 2);
    for (int n = 0; n < 300; n++) begin if (n > 0) @(negedge clk); check(n, 1, 2, "R10", n > 0); end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule